// File: doc/BRIEF.md
# SDRAM Command and Refresh Controller

This block schedules commands for one rank of a four-bank single-data-rate SDRAM with 12-bit rows, 8-bit columns and a 32-bit data bus. A client presents one request at a time with a direction, a bank, a row and a column. The block answers with a one-cycle grant and then produces the row activation and the column command on the registered command pins. Each access uses a closed-page policy: the column command always carries the auto-precharge flag, so no row stays open once its burst ends.

At power-up the block drives no-operation for a programmable number of cycles. It then closes every bank, runs two auto refreshes and loads the mode register, and raises `ready` at that point. A free-running interval counter flags a refresh as due. A due refresh wins over client requests. The block waits until every bank has finished its internal precharge, issues precharge-all, and after the precharge time issues the auto refresh. Every spacing rule is counted in clocks: a shared gap counter for command-to-command rules, one timer per bank for row-cycle and recovery rules, and a small counter for the bank-to-bank activation rule. The data path and burst sequencing belong to a neighbouring block.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held and for at least `INIT_CYCLES` clocks after it is released, the pins carry no-operation ({cs_n,ras_n,cas_n,we_n} = 0111). `sd_cke` is 1, and `ready` and `req_grant` are 0.
- R2: The first four commands after reset are precharge with `sd_addr[10]`=1, auto refresh, auto refresh and mode register set. The mode word has burst-length code in A2:0 (1→0, 2→1, 4→2, 8→3), A3=0 for sequential order, CAS latency in A6:4 and every other bit 0. `ready` rises in the cycle the mode register set appears on the pins.
- R3: The pin codes {cs_n,ras_n,cas_n,we_n} are: activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode register set 0000, no-operation 0111.
- R4: A grant lasts exactly one cycle. In the next cycle an activate appears with `sd_ba` = request bank and `sd_addr` = request row. Exactly `T_RCD` cycles after the activate, a read or write (per `req_write`) appears with the same bank, `sd_addr[7:0]` = column, `sd_addr[10]`=1 and every other address bit 0.
- R5: Two activates to one bank are at least max(`T_RC`, `T_RAS`+`T_RP`) cycles apart. An activate comes at least `BURST_LEN`+`T_RP` cycles after a read to that bank and at least `BURST_LEN`-1+`T_DAL` cycles after a write to it.
- R6: Activates to any two banks are at least `T_RRD` cycles apart.
- R7: Every operational auto refresh comes exactly `T_RP` cycles after a precharge with `sd_addr[10]`=1. With no client traffic, refreshes are exactly `REF_INTERVAL` cycles apart. Under continuous requests to rotating banks, the gap between refreshes never exceeds `REF_INTERVAL`+20.
- R8: No grant is given while `ready` is 0. No command follows a mode register set sooner than `T_MRD` cycles later.
- R9: `sd_cke` stays 1 and every cycle without a scheduled command carries no-operation. No command follows an auto refresh sooner than `T_RRC` cycles, or a precharge sooner than `T_RP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present; held until granted |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bank | input | 2 | Bank of the request |
| req_row | input | 12 | Row of the request |
| req_col | input | 8 | Column of the request |
| req_grant | output | 1 | Request accepted in this cycle |
| ready | output | 1 | Initialization complete |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row, column or mode word; bit 10 is the precharge flag |

## Verification
The bench targets five corner cases. The first is a request that is already pending during initialization; a controller that grants early would put an activate among the power-up commands. The second is a write followed by a read to the same bank; if the write recovery time is lost, the second activate arrives before the bank has finished its auto-precharge. The third is back-to-back requests that rotate across all four banks. If a due refresh does not win over new requests, the refresh never gets onto the pins. If the bank-to-bank activation counter is wrong, two activates come too close together. The fourth is the idle refresh cadence, where a reload error in the interval counter shows up as refreshes one cycle early or late. The fifth is the column command, whose exact distance from the activate and whose precharge flag are checked on every access.

// File: rtl/sdram_ctrl_pkg.sv
`timescale 1ns/1ps
package sdram_ctrl_pkg;

   // pin code ordered {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_BST = 4'b0110,
      CMD_NOP = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_POWERUP,
      ST_INIT_REF1,
      ST_INIT_REF2,
      ST_INIT_MRS,
      ST_IDLE,
      ST_COL,
      ST_REF_PRE,
      ST_REF
   } ctrl_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // mode word: burst-length code, sequential order, CAS latency
   function automatic logic [11:0] mode_word(input int burst_len, input int cas_lat);
      logic [11:0] w;
      w = '0;
      case (burst_len)
         1:       w[2:0] = 3'd0;
         2:       w[2:0] = 3'd1;
         4:       w[2:0] = 3'd2;
         8:       w[2:0] = 3'd3;
         default: w[2:0] = 3'd7;
      endcase
      w[3]   = 1'b0;
      w[6:4] = 3'(cas_lat);
      return w;
   endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
`timescale 1ns/1ps
module sdram_refresh_timer #(
   parameter int INTERVAL = 2080
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);
   localparam int CW = $clog2(INTERVAL + 1);
   localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= RELOAD;
         pending <= 1'b0;
      end else begin
         if (cnt_q == '0) cnt_q <= RELOAD;
         else             cnt_q <= cnt_q - 1'b1;
         if (cnt_q == '0) pending <= 1'b1;
         else if (ack)    pending <= 1'b0;
      end
   end
endmodule

// File: rtl/sdram_bank_timer.sv
`timescale 1ns/1ps
module sdram_bank_timer
   import sdram_ctrl_pkg::*;
#(
   parameter int ACT_HOLD = 9,
   parameter int RD_HOLD  = 7,
   parameter int WR_HOLD  = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_fire,
   input  logic col_fire,
   input  logic col_write,
   output logic free
);
   localparam int HMAX = max2(ACT_HOLD, max2(RD_HOLD, WR_HOLD));
   localparam int CW   = $clog2(HMAX + 1);
   localparam logic [CW-1:0] L_ACT = CW'(ACT_HOLD - 1);
   localparam logic [CW-1:0] L_RD  = CW'(RD_HOLD - 1);
   localparam logic [CW-1:0] L_WR  = CW'(WR_HOLD - 1);

   logic [CW-1:0] cnt_q, dec_v, load_v, col_v;

   always_comb begin
      dec_v  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      col_v  = col_write ? L_WR : L_RD;
      load_v = dec_v;
      if (act_fire && (L_ACT > load_v)) load_v = L_ACT;
      if (col_fire && (col_v > load_v)) load_v = col_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= load_v;
   end

   assign free = (cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_reg.sv
`timescale 1ns/1ps
module sdram_cmd_reg
   import sdram_ctrl_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sd_cmd_e           cmd,
   input  logic [BANK_W-1:0] ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba_q,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
      end else begin
         {cs_n, ras_n, cas_n, we_n} <= cmd;
         ba_q   <= ba;
         addr_q <= addr;
      end
   end
endmodule

// File: rtl/sdram_cmd_ctrl.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl
   import sdram_ctrl_pkg::*;
#(
   parameter int BANK_W       = 2,
   parameter int ROW_W        = 12,
   parameter int COL_W        = 8,
   parameter int AP_BIT       = 10,
   parameter int BURST_LEN    = 4,
   parameter int CAS_LAT      = 3,
   parameter int T_RCD        = 3,
   parameter int T_RP         = 3,
   parameter int T_RAS        = 6,
   parameter int T_RC         = 9,
   parameter int T_RRD        = 2,
   parameter int T_MRD        = 2,
   parameter int T_DAL        = 4,
   parameter int T_RRC        = 9,
   parameter int REF_INTERVAL = 2080,
   parameter int INIT_CYCLES  = 26600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              req_grant,
   output logic              ready,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr
);
   localparam int BANKS    = 2 ** BANK_W;
   localparam int ACT_HOLD = max2(T_RC, T_RAS + T_RP);
   localparam int RD_HOLD  = BURST_LEN + T_RP;
   localparam int WR_HOLD  = BURST_LEN - 1 + T_DAL;
   localparam int GAP_MAX  = max2(INIT_CYCLES, max2(T_RRC, max2(T_RP, max2(T_MRD, T_RCD))));
   localparam int GAP_W    = $clog2(GAP_MAX + 1);
   localparam int RRD_W    = $clog2(T_RRD + 1);
   localparam logic [GAP_W-1:0] G_INIT = GAP_W'(INIT_CYCLES - 1);
   localparam logic [GAP_W-1:0] G_RP   = GAP_W'(T_RP - 1);
   localparam logic [GAP_W-1:0] G_RRC  = GAP_W'(T_RRC - 1);
   localparam logic [GAP_W-1:0] G_MRD  = GAP_W'(T_MRD - 1);
   localparam logic [GAP_W-1:0] G_RCD  = GAP_W'(T_RCD - 1);
   localparam logic [RRD_W-1:0] R_RRD  = RRD_W'(T_RRD - 1);
   localparam logic [11:0]      MODE_W = mode_word(BURST_LEN, CAS_LAT);

   // elaboration-time parameter checks
   if (!(BURST_LEN == 1 || BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bad_bl
      $error("BURST_LEN must be 1, 2, 4 or 8");
   end
   if (!(CAS_LAT == 2 || CAS_LAT == 3)) begin : g_bad_cl
      $error("CAS_LAT must be 2 or 3");
   end
   if (ROW_W <= AP_BIT || COL_W >= AP_BIT || ROW_W < 7) begin : g_bad_addr
      $error("address widths do not leave room for the precharge flag");
   end
   if (T_RCD < 2 || T_RP < 2 || T_RRC < 2 || T_MRD < 1 || T_RRD < 1 || INIT_CYCLES < 1) begin : g_bad_t
      $error("timing parameter out of range");
   end

   ctrl_state_e       state_q, state_d;
   logic [GAP_W-1:0]  gap_q, gap_d;
   logic [RRD_W-1:0]  rrd_q;
   logic              op_q, set_op;
   logic              hold_write_q;
   logic [BANK_W-1:0] hold_bank_q;
   logic [COL_W-1:0]  hold_col_q;
   sd_cmd_e           cmd;
   logic [BANK_W-1:0] cmd_ba;
   logic [ROW_W-1:0]  cmd_addr;
   logic              act_fire, col_fire, ref_ack, ref_pending;
   logic [BANKS-1:0]  bank_free, bank_act, bank_col;

   // per-bank recovery timers
   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign bank_act[b] = act_fire && (req_bank == BANK_W'(b));
      assign bank_col[b] = col_fire && (hold_bank_q == BANK_W'(b));
      sdram_bank_timer #(
         .ACT_HOLD (ACT_HOLD),
         .RD_HOLD  (RD_HOLD),
         .WR_HOLD  (WR_HOLD)
      ) u_timer (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_fire  (bank_act[b]),
         .col_fire  (bank_col[b]),
         .col_write (hold_write_q),
         .free      (bank_free[b])
      );
   end

   sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack     (ref_ack),
      .pending (ref_pending)
   );

   // scheduler
   always_comb begin
      state_d   = state_q;
      gap_d     = (gap_q == '0) ? '0 : gap_q - 1'b1;
      cmd       = CMD_NOP;
      cmd_ba    = '0;
      cmd_addr  = '0;
      req_grant = 1'b0;
      act_fire  = 1'b0;
      col_fire  = 1'b0;
      ref_ack   = 1'b0;
      set_op    = 1'b0;
      if (gap_q == '0) begin
         case (state_q)
            ST_POWERUP: begin
               cmd              = CMD_PRE;
               cmd_addr[AP_BIT] = 1'b1;
               gap_d            = G_RP;
               state_d          = ST_INIT_REF1;
            end
            ST_INIT_REF1: begin
               cmd     = CMD_REF;
               gap_d   = G_RRC;
               state_d = ST_INIT_REF2;
            end
            ST_INIT_REF2: begin
               cmd     = CMD_REF;
               gap_d   = G_RRC;
               state_d = ST_INIT_MRS;
            end
            ST_INIT_MRS: begin
               cmd      = CMD_MRS;
               cmd_addr = ROW_W'(MODE_W);
               gap_d    = G_MRD;
               set_op   = 1'b1;
               state_d  = ST_IDLE;
            end
            ST_IDLE: begin
               if (ref_pending) begin
                  state_d = ST_REF_PRE;
               end else if (req_valid && bank_free[req_bank] && rrd_q == '0) begin
                  cmd       = CMD_ACT;
                  cmd_ba    = req_bank;
                  cmd_addr  = req_row;
                  req_grant = 1'b1;
                  act_fire  = 1'b1;
                  gap_d     = G_RCD;
                  state_d   = ST_COL;
               end
            end
            ST_COL: begin
               cmd                      = hold_write_q ? CMD_WR : CMD_RD;
               cmd_ba                   = hold_bank_q;
               cmd_addr[COL_W-1:0]      = hold_col_q;
               cmd_addr[AP_BIT]         = 1'b1;
               col_fire                 = 1'b1;
               state_d                  = ST_IDLE;
            end
            ST_REF_PRE: begin
               if (&bank_free) begin
                  cmd              = CMD_PRE;
                  cmd_addr[AP_BIT] = 1'b1;
                  gap_d            = G_RP;
                  state_d          = ST_REF;
               end
            end
            ST_REF: begin
               cmd     = CMD_REF;
               gap_d   = G_RRC;
               ref_ack = 1'b1;
               state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_POWERUP;
         gap_q        <= G_INIT;
         rrd_q        <= '0;
         op_q         <= 1'b0;
         hold_write_q <= 1'b0;
         hold_bank_q  <= '0;
         hold_col_q   <= '0;
      end else begin
         state_q <= state_d;
         gap_q   <= gap_d;
         if (act_fire)         rrd_q <= R_RRD;
         else if (rrd_q != '0) rrd_q <= rrd_q - 1'b1;
         if (set_op) op_q <= 1'b1;
         if (req_grant) begin
            hold_write_q <= req_write;
            hold_bank_q  <= req_bank;
            hold_col_q   <= req_col;
         end
      end
   end

   sdram_cmd_reg #(.BANK_W(BANK_W), .ADDR_W(ROW_W)) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd    (cmd),
      .ba     (cmd_ba),
      .addr   (cmd_addr),
      .cs_n   (sd_cs_n),
      .ras_n  (sd_ras_n),
      .cas_n  (sd_cas_n),
      .we_n   (sd_we_n),
      .ba_q   (sd_ba),
      .addr_q (sd_addr)
   );

   assign ready  = op_q;
   assign sd_cke = 1'b1;
endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_grant,
   input logic ready,
   input logic sd_cke,
   input logic sd_cs_n,
   input logic sd_ras_n,
   input logic sd_cas_n,
   input logic sd_we_n,
   input logic ap_flag
);
   logic [3:0] pin_cmd;
   logic       is_nop, is_act, is_col, is_ref;
   assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   assign is_nop  = (pin_cmd == 4'b0111);
   assign is_act  = (pin_cmd == 4'b0011);
   assign is_col  = (pin_cmd == 4'b0101) || (pin_cmd == 4'b0100);
   assign is_ref  = (pin_cmd == 4'b0001);

   AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n) sd_cke); // R9
   AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |-> (ready && req_valid)); // R8
   AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !(is_act || is_col)); // R8
   AST_ACT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |=> is_act); // R4
   AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |=> !req_grant); // R4
   AST_COL_AUTOPRE: assert property (@(posedge clk) disable iff (!rst_n)
      is_col |-> ap_flag); // R4
   AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> is_nop); // R5
   AST_REF_QUIET_BEFORE: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> $past(is_nop)); // R7
endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_grant (req_grant),
   .ready     (ready),
   .sd_cke    (sd_cke),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .ap_flag   (sd_addr[10])
);

// File: tb/sdram_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_bench;
   localparam int BL = 4, T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RRD = 2;
   localparam int T_MRD = 2, T_DAL = 4, T_RRC = 9;
   localparam int REF_IV = 150, INIT_CYC = 20;
   localparam int ACT_HOLD = (T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP;
   localparam int RD_HOLD = BL + T_RP, WR_HOLD = BL - 1 + T_DAL;
   localparam logic [11:0] EXP_MODE = 12'h032;  // BL4 -> 2, CL3 -> A6:4 = 3
   localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010, C_ACT = 4'b0011;
   localparam logic [3:0] C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

   // {write, bank, row, col}
   localparam logic [22:0] VEC [0:7] = '{
      {1'b0, 2'd0, 12'h123, 8'h45},
      {1'b1, 2'd1, 12'h000, 8'h00},
      {1'b1, 2'd2, 12'hABC, 8'h7E},
      {1'b0, 2'd2, 12'h555, 8'h81},
      {1'b0, 2'd3, 12'hFFF, 8'hFF},
      {1'b1, 2'd3, 12'h800, 8'h01},
      {1'b0, 2'd0, 12'h3C3, 8'hA5},
      {1'b1, 2'd1, 12'h7FF, 8'h10}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_bank = '0;
   logic [11:0] req_row = '0;
   logic [7:0] req_col = '0;
   logic req_grant, ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0] sd_ba;
   logic [11:0] sd_addr;

   sdram_cmd_ctrl #(.REF_INTERVAL(REF_IV), .INIT_CYCLES(INIT_CYC)) u_sdram_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_grant(req_grant),
      .ready(ready), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
      .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

   always #2.5 clk = ~clk;

   wire [3:0] pcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // command monitor
   int t_act [4] = '{-1000, -1000, -1000, -1000};
   int t_col [4] = '{-1000, -1000, -1000, -1000};
   bit wr_col [4] = '{0, 0, 0, 0};
   int t_act_any = -1000, t_last = -1000, release_cyc = 0;
   logic [3:0] last_cmd = 4'b0111;
   bit last_pre_all = 1'b0, prev_ready = 1'b0, sat_watch = 1'b0;
   int init_idx = 0, ref_cnt = 0, ref_prev = -1, ref_last = -1, max_gap = 0, early_grant = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!sd_cke) chk(1'b0, "R9 cke", 0, 1);
         if (req_grant && !ready) early_grant++;
         if (pcmd != C_NOP) begin
            if (last_cmd == C_MRS) chk(cyc - t_last >= T_MRD, "R8 tMRD", cyc - t_last, T_MRD);
            if (last_cmd == C_REF) chk(cyc - t_last >= T_RRC, "R9 tRRC", cyc - t_last, T_RRC);
            if (last_cmd == C_PRE) chk(cyc - t_last >= T_RP, "R9 tRP", cyc - t_last, T_RP);
            if (init_idx < 4) begin
               case (init_idx)
                  0: begin
                     chk(pcmd == C_PRE && sd_addr[10], "R2 init precharge-all", pcmd, C_PRE);
                     chk(cyc - release_cyc >= INIT_CYC, "R1 power-up wait", cyc - release_cyc, INIT_CYC);
                  end
                  1, 2: chk(pcmd == C_REF, "R2 init refresh", pcmd, C_REF);
                  default: begin
                     chk(pcmd == C_MRS, "R2 mode set", pcmd, C_MRS);
                     chk(sd_addr == EXP_MODE, "R2 mode word", sd_addr, EXP_MODE);
                     chk(ready && !prev_ready, "R2 ready edge", ready, 1);
                  end
               endcase
               init_idx++;
            end
            case (pcmd)
               C_ACT: begin
                  chk(cyc - t_act[sd_ba] >= ACT_HOLD, "R5 act-act", cyc - t_act[sd_ba], ACT_HOLD);
                  chk(cyc - t_col[sd_ba] >= (wr_col[sd_ba] ? WR_HOLD : RD_HOLD), "R5 col-act",
                      cyc - t_col[sd_ba], wr_col[sd_ba] ? WR_HOLD : RD_HOLD);
                  chk(cyc - t_act_any >= T_RRD, "R6 tRRD", cyc - t_act_any, T_RRD);
                  t_act[sd_ba] = cyc;
                  t_act_any = cyc;
               end
               C_RD, C_WR: begin
                  chk(cyc - t_act[sd_ba] == T_RCD, "R4 tRCD", cyc - t_act[sd_ba], T_RCD);
                  t_col[sd_ba] = cyc;
                  wr_col[sd_ba] = (pcmd == C_WR);
               end
               C_REF: if (ready) begin
                  chk(last_cmd == C_PRE && last_pre_all && cyc - t_last == T_RP, "R7 pre before ref",
                      cyc - t_last, T_RP);
                  ref_prev = ref_last;
                  ref_last = cyc;
                  if (ref_prev >= 0 && sat_watch && ref_last - ref_prev > max_gap)
                     max_gap = ref_last - ref_prev;
                  ref_cnt++;
               end
               default: ;
            endcase
            last_cmd = pcmd;
            last_pre_all = sd_addr[10];
            t_last = cyc;
         end
         prev_ready = ready;
      end
   end

   // one table-driven access with pin checks
   task automatic do_req(input logic [22:0] v);
      int g;
      @(negedge clk);
      {req_write, req_bank, req_row, req_col} = v;
      req_valid = 1'b1;
      g = 0;
      while (g < 400) begin
         #1;
         if (req_grant) break;
         @(negedge clk);
         g++;
      end
      chk(g < 400, "R4 grant", g, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_grant, "R4 single grant", req_grant, 0);
      chk(pcmd == C_ACT && sd_ba == v[21:20] && sd_addr == v[19:8], "R4 R3 activate",
          {pcmd, sd_ba, sd_addr}, {C_ACT, v[21:20], v[19:8]});
      repeat (T_RCD) @(negedge clk);
      chk(pcmd == (v[22] ? C_WR : C_RD) && sd_ba == v[21:20] && sd_addr == (12'h400 | 12'(v[7:0])),
          "R4 R3 column", {pcmd, sd_ba, sd_addr}, {(v[22] ? C_WR : C_RD), v[21:20], 12'h400 | 12'(v[7:0])});
   endtask

   initial begin
      int r0;
      repeat (4) @(negedge clk);
      chk(pcmd == C_NOP && sd_cke && !ready && !req_grant, "R1 reset state",
          {pcmd, sd_cke, ready, req_grant}, {C_NOP, 3'b100});
      {req_write, req_bank, req_row, req_col} = VEC[0];
      req_valid = 1'b1;              // pending before ready: R8
      rst_n = 1'b1;
      release_cyc = cyc;
      repeat (INIT_CYC - 2) @(negedge clk);
      chk(pcmd == C_NOP && !ready, "R1 nop during power-up", pcmd, C_NOP);
      for (int i = 0; i < 8; i++) do_req(VEC[i]);
      chk(early_grant == 0, "R8 no grant before ready", early_grant, 0);
      chk(init_idx == 4, "R2 init commands seen", init_idx, 4);
      // idle refresh cadence
      r0 = ref_cnt;
      for (int k = 0; k < 2000 && ref_cnt < r0 + 3; k++) @(negedge clk);
      chk(ref_last - ref_prev == REF_IV, "R7 idle refresh period", ref_last - ref_prev, REF_IV);
      // saturation: rotate banks with a request always present
      r0 = ref_cnt;
      sat_watch = 1'b1;
      max_gap = 0;
      req_valid = 1'b1;
      for (int i = 0; i < 140; i++) begin
         @(negedge clk);
         req_bank = 2'(i);
         req_write = i[0];
         req_row = 12'(i * 37);
         req_col = 8'(i * 5);
         for (int k = 0; k < 400; k++) begin
            #1;
            if (req_grant) break;
            @(negedge clk);
         end
      end
      @(negedge clk);
      req_valid = 1'b0;
      sat_watch = 1'b0;
      chk(ref_cnt >= r0 + 3, "R7 refresh under load", ref_cnt - r0, 3);
      chk(max_gap <= REF_IV + 20, "R7 refresh priority gap", max_gap, REF_IV + 20);
      repeat (20) @(negedge clk);
      chk(pcmd == C_NOP && sd_cke, "R9 idle nop", pcmd, C_NOP);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected 0", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule